// File: doc/BRIEF.md
# Pin Function Crossbar

This block lets eight port pins each take on one of several on-chip peripheral functions, chosen per pin by a 5-bit function code held in a small register. A simple write/read register bus loads and reads back the eight codes. From the stored code, every pin gets its output value, output enable, open-drain select and input-buffer enable. The level seen on each pin is routed to the peripheral input that the code names.

Most codes give a single function, such as a timer channel, a comparator output, a clock output or a DMA trigger. Codes 11 to 16 each give one serial slot, which the serial peripheral uses for one of two alternative functions. For those codes the peripheral, not the port direction input, decides the pin direction, and the two I2C slots work open-drain. Code 31 isolates the pin so that an analog signal can be applied to it. Reserved codes and code 0 leave the pin driving low under port direction control.

Top module: `pad_fn_xbar`

## Requirements
- R1: Each mapping register keeps only bits [4:0] of the write data. Writing 0xFF reads back 31, and bits [7:5] of the read data are always zero.
- R2: A write with `reg_we` high lands on the rising clock edge that samples it. Before that edge, `reg_rdata` (combinational on `reg_addr`) returns the old code; after it, the new one.
- R3: Synchronous reset loads codes 13, 15, 14, 16, 12, 11, 0, 0 into pins 0 to 7.
- R4: Code 0 and the reserved codes 19 to 30 drive the pin output low, keep the input buffer on and feed no peripheral input.
- R5: Code 31 clears output enable, input enable and output data for that pin. The pin feeds no peripheral input.
- R6: Code 4+k (k = 0..6) drives the pin from timer compare output k and routes the pin to timer capture input k.
- R7: Code 11+s (s = 0..5) drives the pin from serial slot s output data and takes output enable from serial slot s, whatever `port_dir` says. The pin input goes to serial slot s input.
- R8: Codes 14 and 15 set open-drain. Pin output data is 0, and output enable is high only when the slot enables its output with data 0.
- R9: Code 1 outputs comparator 0 and feeds the timer clock input. Code 2 outputs the ADC clock and feeds the DMA trigger. Code 3 outputs the monitor flag and feeds the timer high-impedance input. Code 17 outputs comparator 1, and code 18 outputs the system clock.
- R10: A peripheral input that no pin selects rests at 1 for the six serial inputs and at 0 for all other inputs.
- R11: When several pins select the same peripheral input, the lowest-numbered pin drives it.
- R12: For every code other than 11 to 16 and 31, pin output enable equals that pin's `port_dir` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Pin register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, code in [4:0] |
| pin_in | input | 8 | Pin input levels |
| port_dir | input | 8 | Port direction, 1 = output |
| pin_out | output | 8 | Pin output data |
| pin_oe | output | 8 | Pin output enable |
| pin_od | output | 8 | Pin open-drain select |
| pin_ie | output | 8 | Pin input-buffer enable |
| tmr_cmp_out | input | 7 | Timer compare outputs |
| tmr_cap_in | output | 7 | Timer capture inputs |
| tmr_clk_in | output | 1 | Timer external clock input |
| tmr_hiz_in | output | 1 | Timer output high-impedance request |
| ser_out | input | 6 | Serial slot output data |
| ser_oe | input | 6 | Serial slot output enable |
| ser_in | output | 6 | Serial slot inputs |
| cmp_out0 | input | 1 | Comparator output 0 |
| cmp_out1 | input | 1 | Comparator output 1 |
| adc_clk | input | 1 | ADC clock |
| sys_clk | input | 1 | System clock for output |
| mon_flag | input | 1 | Supply monitor flag |
| dma_trig | output | 1 | DMA trigger input |

## Verification
A table walks one pin through the code classes (none, reserved, analog, timer, single-direction, serial and I2C), each with the peripheral level set to 0 and to 1, the slot enable on and off, and `port_dir` set either way. This separates direction that follows the port from direction the peripheral owns, and a driven level from open-drain release. Per-channel one-hot patterns on the timer compare outputs show that code 4+k picks channel k and no neighbour. Input patterns with two pins on the same target, one of them then turned analog, test lowest-pin priority and isolation. Register writes of 0xFF and 0xE5 test truncation, and a read taken before and after the write edge tests the timing.

// File: rtl/pad_fn_pkg.sv
package pad_fn_pkg;
    localparam int NPIN   = 8;
    localparam int CODE_W = 5;
    localparam int BUS_W  = 8;
    localparam int NTMR   = 7;
    localparam int NSER   = 6;
    // peripheral input targets: target t is fed by code t+1
    localparam int NTGT   = 3 + NTMR + NSER;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t C_NONE   = 5'd0;
    localparam code_t C_CMP0   = 5'd1;
    localparam code_t C_ADCCLK = 5'd2;
    localparam code_t C_MON    = 5'd3;
    localparam code_t C_TMR0   = 5'd4;
    localparam code_t C_SER0   = 5'd11;
    localparam code_t C_SCL    = 5'd14;
    localparam code_t C_SDA    = 5'd15;
    localparam code_t C_CMP1   = 5'd17;
    localparam code_t C_SYSCLK = 5'd18;
    localparam code_t C_ANALOG = 5'd31;

    typedef struct packed {
        logic dat;
        logic oe;
        logic od;
        logic ie;
    } pad_ctl_t;

    function automatic code_t reset_code(input int pin);
        case (pin)
            0:       return 5'd13;
            1:       return 5'd15;
            2:       return 5'd14;
            3:       return 5'd16;
            4:       return 5'd12;
            5:       return 5'd11;
            default: return C_NONE;
        endcase
    endfunction

    function automatic logic is_serial(input code_t c);
        return (c >= C_SER0) && (c < C_SER0 + code_t'(NSER));
    endfunction

    function automatic logic is_open_drain(input code_t c);
        return (c == C_SCL) || (c == C_SDA);
    endfunction

    function automatic logic [NTGT-1:0] idle_targets();
        logic [NTGT-1:0] v;
        v = '0;
        v[NTGT-1 -: NSER] = '1;
        return v;
    endfunction
endpackage

// File: rtl/pad_fn_regs.sv
module pad_fn_regs
    import pad_fn_pkg::*;
#(
    parameter int N  = NPIN,
    parameter int AW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output code_t [N-1:0]     codes
);
    code_t [N-1:0] map_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) map_q[i] <= reset_code(i);
        end else if (reg_we && (int'(reg_addr) < N)) begin
            map_q[reg_addr] <= reg_wdata[CODE_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < N) reg_rdata[CODE_W-1:0] = map_q[reg_addr];
    end

    assign codes = map_q;

    // R1 / R2: a write shows its truncated data after the sampling edge
    p_wr_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (int'(reg_addr) < N)) |=>
            (map_q[$past(reg_addr)] == $past(reg_wdata[CODE_W-1:0])))
        else $error("p_wr_lands_r2");
endmodule

// File: rtl/pad_fn_cell.sv
module pad_fn_cell
    import pad_fn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  code_t           code,
    input  logic            port_dir,
    input  logic [31:0]     code_dat,
    input  logic [NSER-1:0] ser_oe,
    output pad_ctl_t        ctl
);
    localparam int SW = $clog2(NSER);
    logic [SW-1:0] slot;

    always_comb begin
        slot   = SW'(code - C_SER0);
        ctl.dat = 1'b0;
        ctl.oe  = port_dir;
        ctl.od  = 1'b0;
        ctl.ie  = 1'b1;
        if (code == C_ANALOG) begin
            ctl.oe = 1'b0;
            ctl.ie = 1'b0;
        end else if (is_serial(code)) begin
            if (is_open_drain(code)) begin
                ctl.od = 1'b1;
                ctl.oe = ser_oe[slot] & ~code_dat[code];
            end else begin
                ctl.dat = code_dat[code];
                ctl.oe  = ser_oe[slot];
            end
        end else begin
            ctl.dat = code_dat[code];
        end
    end

    p_analog_iso_r5: assert property (@(posedge clk) disable iff (rst)
        (code == C_ANALOG) |-> (!ctl.oe && !ctl.ie && !ctl.dat))
        else $error("p_analog_iso_r5");

    p_od_low_only_r8: assert property (@(posedge clk) disable iff (rst)
        ctl.od |-> !ctl.dat)
        else $error("p_od_low_only_r8");

    p_unmapped_low_r4: assert property (@(posedge clk) disable iff (rst)
        ((code == C_NONE) || ((code > C_SYSCLK) && (code < C_ANALOG))) |->
            (!ctl.dat && ctl.ie && (ctl.oe == port_dir)))
        else $error("p_unmapped_low_r4");
endmodule

// File: rtl/pad_fn_fanin.sv
module pad_fn_fanin
    import pad_fn_pkg::*;
#(
    parameter int N = NPIN
) (
    input  code_t [N-1:0]     codes,
    input  logic  [N-1:0]     pin_in,
    output logic  [NTGT-1:0]  tgt
);
    localparam int TW = $clog2(NTGT);

    always_comb begin
        tgt = idle_targets();
        // walk downward so the lowest pin is applied last and wins
        for (int i = N - 1; i >= 0; i--) begin
            if ((codes[i] >= code_t'(1)) && (codes[i] <= code_t'(NTGT)))
                tgt[TW'(codes[i] - code_t'(1))] = pin_in[i];
        end
    end
endmodule

// File: rtl/pad_fn_xbar.sv
module pad_fn_xbar
    import pad_fn_pkg::*;
#(
    parameter int N  = NPIN,
    parameter int AW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic [N-1:0]      pin_in,
    input  logic [N-1:0]      port_dir,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic [N-1:0]      pin_od,
    output logic [N-1:0]      pin_ie,
    input  logic [NTMR-1:0]   tmr_cmp_out,
    output logic [NTMR-1:0]   tmr_cap_in,
    output logic              tmr_clk_in,
    output logic              tmr_hiz_in,
    input  logic [NSER-1:0]   ser_out,
    input  logic [NSER-1:0]   ser_oe,
    output logic [NSER-1:0]   ser_in,
    input  logic              cmp_out0,
    input  logic              cmp_out1,
    input  logic              adc_clk,
    input  logic              sys_clk,
    input  logic              mon_flag,
    output logic              dma_trig
);
    code_t [N-1:0]    codes;
    logic  [31:0]     code_dat;
    logic  [NTGT-1:0] tgt;

    pad_fn_regs #(.N(N), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .codes(codes)
    );

    // output data offered by each code; unused codes offer 0
    always_comb begin
        code_dat = '0;
        code_dat[C_CMP0]             = cmp_out0;
        code_dat[C_ADCCLK]           = adc_clk;
        code_dat[C_MON]              = mon_flag;
        code_dat[C_TMR0 +: NTMR]     = tmr_cmp_out;
        code_dat[C_SER0 +: NSER]     = ser_out;
        code_dat[C_CMP1]             = cmp_out1;
        code_dat[C_SYSCLK]           = sys_clk;
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        pad_ctl_t ctl;
        pad_fn_cell u_cell (
            .clk(clk), .rst(rst), .code(codes[g]), .port_dir(port_dir[g]),
            .code_dat(code_dat), .ser_oe(ser_oe), .ctl(ctl)
        );
        assign pin_out[g] = ctl.dat;
        assign pin_oe[g]  = ctl.oe;
        assign pin_od[g]  = ctl.od;
        assign pin_ie[g]  = ctl.ie;
    end

    pad_fn_fanin #(.N(N)) u_fanin (.codes(codes), .pin_in(pin_in), .tgt(tgt));

    assign tmr_clk_in = tgt[0];
    assign dma_trig   = tgt[1];
    assign tmr_hiz_in = tgt[2];
    assign tmr_cap_in = tgt[3 +: NTMR];
    assign ser_in     = tgt[3 + NTMR +: NSER];

    // R11: pin 0 beats pin 1 when both name the same input
    p_lowest_wins_r11: assert property (@(posedge clk) disable iff (rst)
        ((codes[0] == codes[1]) && (codes[0] >= code_t'(1)) &&
         (codes[0] <= code_t'(NTGT))) |->
            (tgt[codes[0] - code_t'(1)] == pin_in[0]))
        else $error("p_lowest_wins_r11");
endmodule

// File: tb/test_pad_fn_xbar.sv
module test_pad_fn_xbar;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = '0, port_dir = '0;
    logic [7:0] pin_out, pin_oe, pin_od, pin_ie;
    logic [6:0] tmr_cmp_out = '0, tmr_cap_in;
    logic       tmr_clk_in, tmr_hiz_in, dma_trig;
    logic [5:0] ser_out = '0, ser_oe = '0, ser_in;
    logic cmp_out0 = 0, cmp_out1 = 0, adc_clk = 0, sys_clk = 0, mon_flag = 0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pad_fn_xbar i_pad_fn_xbar (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_od(pin_od), .pin_ie(pin_ie), .tmr_cmp_out(tmr_cmp_out),
        .tmr_cap_in(tmr_cap_in), .tmr_clk_in(tmr_clk_in),
        .tmr_hiz_in(tmr_hiz_in), .ser_out(ser_out), .ser_oe(ser_oe),
        .ser_in(ser_in), .cmp_out0(cmp_out0), .cmp_out1(cmp_out1),
        .adc_clk(adc_clk), .sys_clk(sys_clk), .mon_flag(mon_flag),
        .dma_trig(dma_trig)
    );

    // {code[4:0], periph level, slot oe, port_dir, exp out, oe, od, ie}
    localparam int NV = 17;
    localparam logic [11:0] VEC [NV] = '{
        {5'd0,  3'b101, 4'b0101},
        {5'd0,  3'b100, 4'b0001},
        {5'd20, 3'b101, 4'b0101},
        {5'd30, 3'b111, 4'b0101},
        {5'd31, 3'b111, 4'b0000},
        {5'd5,  3'b101, 4'b1101},
        {5'd5,  3'b000, 4'b0001},
        {5'd1,  3'b101, 4'b1101},
        {5'd18, 3'b100, 4'b1001},
        {5'd17, 3'b101, 4'b1101},
        {5'd11, 3'b110, 4'b1101},
        {5'd11, 3'b001, 4'b0001},
        {5'd14, 3'b010, 4'b0111},
        {5'd14, 3'b111, 4'b0011},
        {5'd15, 3'b001, 4'b0011},
        {5'd2,  3'b001, 4'b0101},
        {5'd3,  3'b101, 4'b1101}
    };

    function automatic string tag_of(input logic [4:0] c);
        if (c == 5'd31) return "R5";
        if (c == 5'd14 || c == 5'd15) return "R8";
        if (c >= 5'd11 && c <= 5'd16) return "R7";
        if (c >= 5'd4 && c <= 5'd10) return "R6";
        if (c == 5'd0 || c >= 5'd19) return "R4/R12";
        return "R9/R12";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
        reg_addr = 3'(a);
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic set_periph(input logic lvl, input logic soe);
        tmr_cmp_out = {7{lvl}}; ser_out = {6{lvl}}; ser_oe = {6{soe}};
        cmp_out0 = lvl; cmp_out1 = lvl; adc_clk = lvl; sys_clk = lvl; mon_flag = lvl;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [4:0] defs [8];
        logic [5:0] exp_ser;
        defs = '{5'd13, 5'd15, 5'd14, 5'd16, 5'd12, 5'd11, 5'd0, 5'd0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3 reset defaults
        for (int i = 0; i < 8; i++) rd_chk("R3 reset code", i, {3'b0, defs[i]});

        // R7 input fan-in with default serial mapping
        pin_in = 8'b0011_0101;
        #1;
        exp_ser = '0;
        for (int i = 0; i < 6; i++) exp_ser[defs[i] - 5'd11] = pin_in[i];
        chk("R7 serial inputs", 32'(ser_in), 32'(exp_ser));
        pin_in = 8'b1100_1010;
        #1;
        for (int i = 0; i < 6; i++) exp_ser[defs[i] - 5'd11] = pin_in[i];
        chk("R7 serial inputs alt", 32'(ser_in), 32'(exp_ser));

        // R1 truncation
        wr(7, 8'hFF);
        rd_chk("R1 0xFF reads 31", 7, 8'd31);
        wr(7, 8'hE5);
        rd_chk("R1 0xE5 reads 5", 7, 8'd5);
        wr(7, 8'h00);

        // R2 write timing: old before edge, new after
        @(negedge clk);
        reg_addr = 3'd6; reg_wdata = 8'd9; reg_we = 1'b1;
        #1;
        chk("R2 old value before edge", 32'(reg_rdata), 32'd0);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R2 new value after edge", 32'(reg_rdata), 32'd9);

        // table walk on pin 6
        for (int v = 0; v < NV; v++) begin
            wr(6, {3'b0, VEC[v][11:7]});
            set_periph(VEC[v][6], VEC[v][5]);
            port_dir = {8{VEC[v][4]}};
            #1;
            chk(tag_of(VEC[v][11:7]),
                32'({pin_out[6], pin_oe[6], pin_od[6], pin_ie[6]}),
                32'(VEC[v][3:0]));
        end
        set_periph(1'b0, 1'b0);
        port_dir = 8'hFF;

        // R6 timer channel selection and capture routing
        for (int k = 0; k < 7; k++) begin
            wr(6, 8'(4 + k));
            tmr_cmp_out = 7'(1 << k);
            pin_in = 8'h40;
            #1;
            chk("R6 compare picked", 32'(pin_out[6]), 32'd1);
            chk("R6 capture routed", 32'(tmr_cap_in), 32'(1 << k));
            tmr_cmp_out = ~7'(1 << k);
            #1;
            chk("R6 other channels", 32'(pin_out[6]), 32'd0);
        end
        tmr_cmp_out = '0;

        // R10 idle values with every pin unmapped (R4: no input feed)
        for (int i = 0; i < 8; i++) wr(i, 8'd0);
        pin_in = 8'hFF;
        #1;
        chk("R10 idle others high pins", 32'({tmr_cap_in, tmr_clk_in, tmr_hiz_in, dma_trig}), 32'd0);
        chk("R10 serial idle high", 32'(ser_in), 32'h3F);
        pin_in = 8'h00;
        #1;
        chk("R10 serial idle low pins", 32'(ser_in), 32'h3F);

        // R9 single-direction inputs
        wr(3, 8'd1); pin_in = 8'h08; #1;
        chk("R9 timer clock in", 32'(tmr_clk_in), 32'd1);
        wr(3, 8'd2); #1;
        chk("R9 dma trigger", 32'(dma_trig), 32'd1);
        wr(3, 8'd3); #1;
        chk("R9 timer hiz in", 32'(tmr_hiz_in), 32'd1);
        wr(3, 8'd0);

        // R11 lowest pin wins; R5 analog pin drops out
        wr(2, 8'd6); wr(5, 8'd6);
        pin_in = 8'b0010_0000; #1;
        chk("R11 pin2 low wins", 32'(tmr_cap_in[2]), 32'd0);
        pin_in = 8'b0000_0100; #1;
        chk("R11 pin2 high wins", 32'(tmr_cap_in[2]), 32'd1);
        wr(2, 8'd31); #1;
        chk("R5 analog pin feeds nothing", 32'(tmr_cap_in[2]), 32'd0);
        pin_in = 8'b0010_0000; #1;
        chk("R5 next pin takes over", 32'(tmr_cap_in[2]), 32'd1);

        // R3 reset restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R3 reset again pin2", 2, 8'd14);
        rd_chk("R3 reset again pin5", 5, 8'd11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule